// File: doc/BRIEF.md
# Fault Flag and Scan Watchdog Unit

This unit collects the protection conditions of a multi-channel constant-current LED sink and turns them into one output shutdown and two active-low, open-drain fault flags. A scan watchdog watches a trigger input that a display controller toggles once per scan line. When the trigger stops changing level for a programmable number of clock cycles, the outputs are shut down. The shutdown lifts again as soon as the trigger moves. A thermal trip input, gated by a thermal enable, latches a shutdown that stays in place until the enable is taken low or the unit is reset.

The second flag reports the output-voltage monitor. Each channel has a comparator bit that says its output sits below the selected threshold. Only channels that are switched on count. The combined result is sampled on each clock while blank is low and frozen while blank is high, so a host can read it at any time after a lit period. A 4-bit monitor code picks the comparator threshold, turns comparison off, or forces either flag low so that the wiring of the flags to the system can be tested. Each flag is modelled as a pull-low enable together with the level that a pull-up would produce.

Top module: `fault_guard`

## Requirements
- R1: With the watchdog enabled and the synchronized trigger unchanged, shutdown asserts on the clock edge that ends the timeout of TIMEOUT = BASE_CYCLES + EXTEND_CYCLES cycles. Counting starts from zero after reset, after wd_off falls, or after the last detected level change.
- R2: After a watchdog trip, a level change on scan_trig clears shutdown on the (SYNC_STAGES+1)-th rising clock edge after the change, and not earlier.
- R3: A trigger that changes level more often than once per TIMEOUT cycles never causes a shutdown.
- R4: While wd_off is high, the watchdog cannot trip, and a trip already in place clears on the next clock edge.
- R5: When therm_en and over_temp are both high at a clock edge, shutdown asserts after that edge and stays asserted after over_temp falls. While therm_en is low, over_temp has no effect.
- R6: A thermal shutdown is cleared only by therm_en low (after the next edge) or by reset.
- R7: shutdown is the OR of the watchdog trip and the thermal latch, and fault1_oe is high whenever shutdown is high.
- R8: The held monitor result is the OR over all channels of (cmp_low[i] AND ch_on[i]). It is sampled at every clock edge where blank is low and is visible one edge after the inputs are applied.
- R9: While blank is high, the held monitor result does not change, whatever cmp_low and ch_on do.
- R10: Monitor codes behave as follows. For code 0000, fault2_oe is 0 and thr_sel is 0. For code 1110, fault1_oe is 1 and fault2_oe is 0. For code 1111, fault2_oe is 1. For codes 0001 to 1101, fault2_oe equals the held result and thr_sel equals the code. For codes 0000, 1110 and 1111, thr_sel is 0.
- R11: fault1_n and fault2_n are the inverse of fault1_oe and fault2_oe (the level seen through an external pull-up). All outputs are low after reset, apart from the _n levels, which are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_trig | input | 1 | Scan trigger watched by the watchdog (asynchronous) |
| wd_off | input | 1 | High disables the watchdog |
| therm_en | input | 1 | Thermal trip enable; low clears the thermal latch |
| over_temp | input | 1 | Over-temperature indication |
| cmp_low | input | NCH | Per-channel comparator: output below threshold |
| ch_on | input | NCH | Per-channel on enable |
| blank | input | 1 | High holds the monitor result |
| mon_code | input | 4 | Monitor control code |
| shutdown | output | 1 | Turns all channel outputs off |
| fault1_oe | output | 1 | Pull-low enable of fault flag 1 |
| fault1_n | output | 1 | Resolved level of fault flag 1 |
| fault2_oe | output | 1 | Pull-low enable of fault flag 2 |
| fault2_n | output | 1 | Resolved level of fault flag 2 |
| thr_sel | output | 4 | Comparator threshold select |

## Verification
A wrong idle count or a missed trigger edge shows up at shutdown and fault1_oe. Shutdown either rises one or more cycles away from the exact timeout edge, or it fails to clear on the (SYNC_STAGES+1)-th edge after a trigger change, so every trip and recovery is checked on its exact edge. A thermal latch that leaks shows up as shutdown dropping while over_temp is low and therm_en is still high. A stale or unheld monitor register shows up at fault2_oe one edge after a change in the comparator pattern, or while blank is high. The code decoding is visible at once at the flags and at thr_sel.

// File: rtl/fault_pkg.sv
package fault_pkg;

    typedef logic [3:0] mon_code_t;

    localparam mon_code_t CODE_IDLE     = 4'b0000;
    localparam mon_code_t CODE_FORCE_F1 = 4'b1110;
    localparam mon_code_t CODE_FORCE_F2 = 4'b1111;

    // True for codes that select a comparator threshold
    function automatic logic code_compares(input mon_code_t c);
        return (c != CODE_IDLE) && (c != CODE_FORCE_F1) && (c != CODE_FORCE_F2);
    endfunction

endpackage

// File: rtl/fg_scan_wdog.sv
module fg_scan_wdog #(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_trig,
    input  logic wd_off,
    output logic wd_trip
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [CW-1:0]          cnt;
        logic                   trip;
    } wd_state_t;

    wd_state_t st_d, st_q;
    logic      sample;
    logic      level_moved;

    assign sample      = st_q.sync[SYNC_STAGES-1];
    assign level_moved = sample ^ st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.sync = SYNC_STAGES'({st_q.sync, scan_trig});
        st_d.prev = sample;
        if (wd_off || level_moved) begin
            st_d.cnt  = '0;
            st_d.trip = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.trip = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wd_trip = st_q.trip;

    // R1: a trip only begins when the idle count has reached its final value
    a_r1_trip_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.trip) |-> $past(st_q.cnt) == LAST);

    // R2: a detected level change releases the trip on the next edge
    a_r2_edge_recovers: assert property (@(posedge clk) disable iff (!rst_n)
        level_moved |=> !st_q.trip);

    // R4: disable keeps the counter idle and the trip clear
    a_r4_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off |=> (!st_q.trip && st_q.cnt == '0));

endmodule

// File: rtl/fg_therm_latch.sv
module fg_therm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic therm_en,
    input  logic over_temp,
    output logic therm_trip
);
    typedef struct packed {
        logic hot;
    } th_state_t;

    th_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!therm_en)      st_d.hot = 1'b0;
        else if (over_temp) st_d.hot = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign therm_trip = st_q.hot;

    // R5: once latched with the enable high, the trip persists
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_en && st_q.hot) |=> st_q.hot);

    // R6: enable low clears the latch
    a_r6_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !therm_en |=> !st_q.hot);

endmodule

// File: rtl/fg_mon_hold.sv
module fg_mon_hold
    import fault_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmp_low,
    input  logic [NCH-1:0] ch_on,
    input  logic           blank,
    input  mon_code_t      mon_code,
    output logic           force_f1,
    output logic           flag2_pull,
    output mon_code_t      thr_sel
);
    typedef struct packed {
        logic held;
    } mh_state_t;

    mh_state_t      st_d, st_q;
    logic [NCH-1:0] ch_fault;
    logic           any_fault;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign ch_fault[i] = cmp_low[i] & ch_on[i];
        end
    endgenerate

    assign any_fault = |ch_fault;

    always_comb begin
        st_d = st_q;
        if (!blank) st_d.held = any_fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        force_f1   = (mon_code == CODE_FORCE_F1);
        thr_sel    = code_compares(mon_code) ? mon_code : CODE_IDLE;
        flag2_pull = 1'b0;
        if (mon_code == CODE_FORCE_F2)     flag2_pull = 1'b1;
        else if (code_compares(mon_code))  flag2_pull = st_q.held;
    end

    // R9: blank high freezes the held result
    a_r9_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> $stable(st_q.held));

    // R10: idle code and flag-1 test code leave flag 2 released
    a_r10_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_code == CODE_IDLE || mon_code == CODE_FORCE_F1) |-> !flag2_pull);

endmodule

// File: rtl/fault_guard.sv
module fault_guard
    import fault_pkg::*;
#(
    parameter int NCH           = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int BASE_CYCLES   = 500000,
    parameter int EXTEND_CYCLES = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_trig,
    input  logic           wd_off,
    input  logic           therm_en,
    input  logic           over_temp,
    input  logic [NCH-1:0] cmp_low,
    input  logic [NCH-1:0] ch_on,
    input  logic           blank,
    input  logic [3:0]     mon_code,
    output logic           shutdown,
    output logic           fault1_oe,
    output logic           fault1_n,
    output logic           fault2_oe,
    output logic           fault2_n,
    output logic [3:0]     thr_sel
);
    localparam int TIMEOUT = BASE_CYCLES + EXTEND_CYCLES;

    logic wd_trip;
    logic therm_trip;
    logic force_f1;
    logic flag2_pull;

    fg_scan_wdog #(
        .SYNC_STAGES (SYNC_STAGES),
        .TIMEOUT     (TIMEOUT)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_trig (scan_trig),
        .wd_off    (wd_off),
        .wd_trip   (wd_trip)
    );

    fg_therm_latch u_therm (
        .clk        (clk),
        .rst_n      (rst_n),
        .therm_en   (therm_en),
        .over_temp  (over_temp),
        .therm_trip (therm_trip)
    );

    fg_mon_hold #(
        .NCH (NCH)
    ) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_low    (cmp_low),
        .ch_on      (ch_on),
        .blank      (blank),
        .mon_code   (mon_code),
        .force_f1   (force_f1),
        .flag2_pull (flag2_pull),
        .thr_sel    (thr_sel)
    );

    assign shutdown  = wd_trip | therm_trip;
    assign fault1_oe = shutdown | force_f1;
    assign fault2_oe = flag2_pull;
    assign fault1_n  = ~fault1_oe;
    assign fault2_n  = ~fault2_oe;

    // R7: any shutdown pulls flag 1
    a_r7_shutdown_flags: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> fault1_oe);

    // R10: the flag-2 test code always pulls flag 2
    a_r10_force_f2: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_code == CODE_FORCE_F2) |-> fault2_oe);

    // R11: resolved level is never the same as the pull enable
    a_r11_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (fault1_n != fault1_oe) && (fault2_n != fault2_oe));

endmodule

// File: tb/tb_fault_guard.sv
module tb_fault_guard;
    localparam int NCH   = 16;
    localparam int SYNC  = 2;
    localparam int BASE  = 20;
    localparam int EXT   = 5;
    localparam int LIMIT = BASE + EXT;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scan_trig = 1'b0;
    logic           wd_off = 1'b1;
    logic           therm_en = 1'b0;
    logic           over_temp = 1'b0;
    logic [NCH-1:0] cmp_low = '0;
    logic [NCH-1:0] ch_on = '0;
    logic           blank = 1'b0;
    logic [3:0]     mon_code = 4'b0000;
    logic           shutdown, fault1_oe, fault1_n, fault2_oe, fault2_n;
    logic [3:0]     thr_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fault_guard #(
        .NCH(NCH), .SYNC_STAGES(SYNC), .BASE_CYCLES(BASE), .EXTEND_CYCLES(EXT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .scan_trig(scan_trig), .wd_off(wd_off),
        .therm_en(therm_en), .over_temp(over_temp), .cmp_low(cmp_low),
        .ch_on(ch_on), .blank(blank), .mon_code(mon_code),
        .shutdown(shutdown), .fault1_oe(fault1_oe), .fault1_n(fault1_n),
        .fault2_oe(fault2_oe), .fault2_n(fault2_n), .thr_sel(thr_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset shutdown", shutdown, 0);
        chk("R11 reset fault1_oe", fault1_oe, 0);
        chk("R11 reset fault2_oe", fault2_oe, 0);
        chk("R11 reset fault1_n", fault1_n, 1);
        chk("R11 reset thr_sel", thr_sel, 0);
        waitc(2);
        rst_n = 1'b1;
        waitc(3);

        // R1: exact timeout from disable release
        wd_off = 1'b0;
        waitc(LIMIT - 1);
        chk("R1 before timeout", shutdown, 0);
        waitc(1);
        chk("R1 at timeout", shutdown, 1);
        chk("R7 fault1 with wd trip", fault1_oe, 1);
        chk("R11 fault1_n with trip", fault1_n, 0);

        // R2: recovery on exact edge
        scan_trig = ~scan_trig;
        waitc(SYNC);
        chk("R2 not yet recovered", shutdown, 1);
        waitc(1);
        chk("R2 recovered", shutdown, 0);
        // counter restarted at that edge
        waitc(LIMIT - 1);
        chk("R1 timeout after change, before", shutdown, 0);
        waitc(1);
        chk("R1 timeout after change", shutdown, 1);

        // R3: steady toggling never trips
        for (int k = 0; k < 20; k++) begin
            scan_trig = ~scan_trig;
            waitc(10);
            if (k > 0) chk("R3 toggling keeps on", shutdown, 0);
        end

        // R4: disable clears an active trip and suppresses
        waitc(LIMIT + 5);
        chk("R4 trip before disable", shutdown, 1);
        wd_off = 1'b1;
        waitc(1);
        chk("R4 disable clears", shutdown, 0);
        for (int k = 0; k < 6; k++) begin
            waitc(LIMIT / 2);
            chk("R4 disabled no trip", shutdown, 0);
        end

        // R5: thermal latch
        therm_en = 1'b1; over_temp = 1'b1;
        waitc(1);
        chk("R5 thermal trip", shutdown, 1);
        chk("R7 fault1 with thermal", fault1_oe, 1);
        over_temp = 1'b0;
        waitc(10);
        chk("R5 thermal latched", shutdown, 1);
        // R6: enable low clears
        therm_en = 1'b0;
        waitc(1);
        chk("R6 enable clears", shutdown, 0);
        chk("R6 fault1 released", fault1_oe, 0);
        over_temp = 1'b1;
        waitc(3);
        chk("R5 ignored when disabled", shutdown, 0);
        therm_en = 1'b1;
        waitc(1);
        chk("R5 trip on enable", shutdown, 1);
        rst_n = 1'b0;
        #1;
        chk("R6 reset clears", shutdown, 0);
        waitc(1);
        rst_n = 1'b1;
        therm_en = 1'b0; over_temp = 1'b0;
        waitc(1);

        // R8: single channel sweep, code 0101
        mon_code = 4'b0101;
        for (int i = 0; i < NCH; i++) begin
            cmp_low = NCH'(1) << i;
            ch_on   = '1;
            waitc(1);
            chk("R8 channel on low", fault2_oe, 1);
            chk("R11 fault2_n", fault2_n, 0);
            ch_on   = ~(NCH'(1) << i);
            waitc(1);
            chk("R8 channel off ignored", fault2_oe, 0);
        end
        // R8: pseudo-random patterns
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 64; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cmp_low = lfsr[15:0];
            ch_on   = lfsr[31:16] & {lfsr[7:0], lfsr[15:8]};
            waitc(1);
            chk("R8 pattern", fault2_oe, ((cmp_low & ch_on) != '0) ? 1 : 0);
        end

        // R9: blank holds
        cmp_low = 16'h0010; ch_on = 16'h0010;
        waitc(1);
        chk("R9 setup set", fault2_oe, 1);
        blank = 1'b1;
        cmp_low = '0;
        waitc(5);
        chk("R9 held high under blank", fault2_oe, 1);
        blank = 1'b0;
        waitc(1);
        chk("R9 released after blank", fault2_oe, 0);
        blank = 1'b1;
        cmp_low = '1; ch_on = '1;
        waitc(5);
        chk("R9 held low under blank", fault2_oe, 0);

        // R10: full code sweep with held result 0 then 1
        for (int h = 0; h < 2; h++) begin
            blank = 1'b0;
            cmp_low = (h == 1) ? '1 : '0;
            ch_on = '1;
            waitc(1);
            blank = 1'b1;
            for (int c = 0; c < 16; c++) begin
                int e1, e2, et;
                mon_code = 4'(c);
                #1;
                e1 = (c == 14) ? 1 : 0;
                e2 = (c == 15) ? 1 : ((c == 0 || c == 14) ? 0 : h);
                et = (c >= 1 && c <= 13) ? c : 0;
                chk("R10 fault1_oe", fault1_oe, e1);
                chk("R10 fault2_oe", fault2_oe, e2);
                chk("R10 thr_sel", thr_sel, et);
                chk("R11 fault1_n", fault1_n, 1 - e1);
                waitc(1);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule